// File: doc/BRIEF.md
# Memory-Mapped ATA Register Window

This block puts the task-file registers of an ATA/IDE drive interface on a host memory bus. It looks at the low 12 address bits only, and it places each register in its own 16-byte slot. The host may issue byte, halfword or word accesses. Byte accesses reach the eight-bit task-file registers and the device-control register. Halfword and word accesses reach only the data port.

A parameter can swap the byte lanes of data-port traffic, so that a big-endian host sees drive data in its natural order. A word access to the data port reaches the drive side as two halfword strobes on consecutive cycles. A level interrupt goes to an interrupt controller: drive completion sets it unless the drive interrupt is masked, and a read of the main status register clears it. A small register stub stands in for the drive. It stores the task-file bytes and keeps data-port halfwords in a first-in first-out buffer.

Top module: `ata_mmio_window`

## Requirements
- R1: After synchronous reset, `irq` and `bus_ready` are 0 and the interrupt mask is clear, so a later `dev_done` pulse sets `irq` with no device-control write in between.
- R2: Only `bus_addr[11:0]` is decoded. The register index is `bus_addr[11:4]`. Address bits above 11 and the low four bits have no effect on which register is reached.
- R3: A byte write (`bus_size`=0) to index 1..7 stores `bus_wdata[7:0]` in that task-file register. A byte read returns the stored byte in `bus_rdata[7:0]`, with bits 31:8 at zero. A read of index 7 returns the last byte written at index 7.
- R4: Indices 8 and 22 both reach the device-control register on byte writes, and bit 1 of the written byte masks the interrupt. A byte read of either index returns the index-7 byte and leaves `irq` unchanged.
- R5: A byte read of any index other than 1..8 and 22 returns 0x000000FF. A byte write there changes no register.
- R6: A halfword (`bus_size`=1) or word (`bus_size`=2 or 3) access at a nonzero index reads 0x0000FFFF or 0xFFFFFFFF and writes nothing.
- R7: Data-port halfwords at index 0 are kept in order of arrival. With BIG_ENDIAN=0 a halfword passes unchanged. With BIG_ENDIAN=1 its two bytes are swapped both when it is written and when it is read.
- R8: A data-port word is byte-reversed first when BIG_ENDIAN=1. It then goes to the drive side as two halfwords, bits 15:0 first. A word read puts the first halfword it pops in bits 15:0 and then applies the same reversal.
- R9: `bus_ready` pulses for one cycle. It rises one cycle after `bus_req` for every access except a data-port word, where it rises two cycles after `bus_req`.
- R10: A `dev_done` pulse sets `irq` on the next cycle only while the mask bit is 0. While the mask bit is 1, `irq` stays unchanged.
- R11: A byte read of index 7 clears `irq` on the next cycle. If `dev_done` arrives in the same cycle with the mask clear, `irq` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, byte lanes taken from the low bits |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| dev_done | input | 1 | Drive-side completion pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the host raises `bus_req` for one cycle and waits for `bus_ready` before it starts the next access. A request that arrives during the second half of a data-port word would be dropped. The bench drives every access through one task that holds off until the ready pulse, so this rule always holds. The bench also keeps the occupancy of its data-port model between empty and the buffer depth, so that no read pops an empty buffer and no write overruns a full one.

// File: rtl/ata_win_pkg.sv
package ata_win_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TF   = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_DATA = 2'd3
  } sel_e;

  localparam int IDX_STATUS = 7;
  localparam int IDX_CTL_A  = 8;
  localparam int IDX_CTL_B  = 22;
  localparam int MASK_BIT   = 1;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/ata_win_decode.sv
module ata_win_decode
  import ata_win_pkg::*;
#(
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  localparam int IDX_W      = WIN_BITS - STRIDE_BITS
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             is_byte,
  output sel_e             sel
);
  always_comb begin
    sel = SEL_NONE;
    if (is_byte) begin
      if (idx >= IDX_W'(1) && idx <= IDX_W'(IDX_STATUS))
        sel = SEL_TF;
      else if (idx == IDX_W'(IDX_CTL_A) || idx == IDX_W'(IDX_CTL_B))
        sel = SEL_CTL;
    end else if (idx == '0) begin
      sel = SEL_DATA;
    end
  end
endmodule

// File: rtl/ata_win_stub.sv
module ata_win_stub #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tf_we,
  input  logic [2:0]  tf_idx,
  input  logic [7:0]  tf_wdata,
  output logic [7:0]  tf_rdata,
  input  logic        ctl_we,
  input  logic        ctl_mask_in,
  output logic        mask,
  input  logic        dp_wr,
  input  logic        dp_rd,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata
);
  logic [7:0]       tf_mem [8];
  logic [15:0]      fifo_mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             mask_q;

  always_ff @(posedge clk) begin
    if (tf_we) tf_mem[tf_idx] <= tf_wdata;
  end

  always_ff @(posedge clk) begin
    if (dp_wr) fifo_mem[wptr] <= dp_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      mask_q <= 1'b0;
    end else begin
      if (dp_wr)  wptr   <= wptr + 1'b1;
      if (dp_rd)  rptr   <= rptr + 1'b1;
      if (ctl_we) mask_q <= ctl_mask_in;
    end
  end

  assign tf_rdata = tf_mem[tf_idx];
  assign dp_rdata = fifo_mem[rptr];
  assign mask     = mask_q;
endmodule

// File: rtl/ata_win_irq.sv
module ata_win_irq (
  input  logic clk,
  input  logic rst,
  input  logic dev_done,
  input  logic mask,
  input  logic status_rd,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)                    irq_q <= 1'b0;
    else if (dev_done && !mask) irq_q <= 1'b1;
    else if (status_rd)         irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_done && !mask) |=> irq);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !(dev_done && !mask)) |=> !irq);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_done && mask && !status_rd) |=> $stable(irq));
endmodule

// File: rtl/ata_mmio_window.sv
module ata_mmio_window
  import ata_win_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int DATA_DEPTH  = 16,
  parameter bit BIG_ENDIAN  = 1'b0,
  localparam int IDX_W      = WIN_BITS - STRIDE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic              dev_done,
  output logic              irq
);
  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             is_byte, is_word, start, word_data;
  logic             busy_q, we_q, ready_q;
  logic [15:0]      hi_q, lo_q;
  logic [31:0]      rdata_q, rd_value, word_rd;
  logic [31:0]      w_dev;
  logic [15:0]      h_dev, h_bus;
  logic             tf_we, ctl_we, status_rd, dp_wr, dp_rd, mask;
  logic [2:0]       stub_idx;
  logic [7:0]       tf_rdata;
  logic [15:0]      dp_wdata, dp_rdata;
  logic             addr_unused;

  assign idx         = bus_addr[WIN_BITS-1:STRIDE_BITS];
  assign addr_unused = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_addr[STRIDE_BITS-1:0]};
  assign is_byte     = (bus_size == 2'd0);
  assign is_word     = bus_size[1];
  assign start       = bus_req && !busy_q;
  assign word_data   = (sel == SEL_DATA) && is_word;

  ata_win_decode #(.WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS)) u_decode (
    .idx(idx), .is_byte(is_byte), .sel(sel)
  );

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign w_dev   = swap32(bus_wdata);
      assign h_dev   = swap16(bus_wdata[15:0]);
      assign h_bus   = swap16(dp_rdata);
      assign word_rd = swap32({dp_rdata, lo_q});
    end else begin : g_pass
      assign w_dev   = bus_wdata;
      assign h_dev   = bus_wdata[15:0];
      assign h_bus   = dp_rdata;
      assign word_rd = {dp_rdata, lo_q};
    end
  endgenerate

  assign tf_we     = start && bus_we && (sel == SEL_TF);
  assign ctl_we    = start && bus_we && (sel == SEL_CTL);
  assign status_rd = start && !bus_we && (sel == SEL_TF) && (idx[2:0] == 3'(IDX_STATUS));
  assign stub_idx  = (sel == SEL_CTL) ? 3'(IDX_STATUS) : idx[2:0];
  assign dp_wr     = (start && bus_we && (sel == SEL_DATA)) || (busy_q && we_q);
  assign dp_rd     = (start && !bus_we && (sel == SEL_DATA)) || (busy_q && !we_q);
  assign dp_wdata  = busy_q ? hi_q : (is_word ? w_dev[15:0] : h_dev);

  always_comb begin
    unique case (sel)
      SEL_TF, SEL_CTL: rd_value = {24'd0, tf_rdata};
      SEL_DATA:        rd_value = {16'd0, h_bus};
      default:         rd_value = is_word ? 32'hFFFF_FFFF :
                                  (is_byte ? 32'h0000_00FF : 32'h0000_FFFF);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      ready_q <= 1'b0;
      rdata_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      ready_q <= 1'b0;
      if (busy_q) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
        rdata_q <= we_q ? 32'd0 : word_rd;
      end else if (bus_req) begin
        if (word_data) begin
          busy_q <= 1'b1;
          we_q   <= bus_we;
          hi_q   <= w_dev[31:16];
          lo_q   <= dp_rdata;
        end else begin
          ready_q <= 1'b1;
          rdata_q <= bus_we ? 32'd0 : rd_value;
        end
      end
    end
  end

  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;

  ata_win_stub #(.DEPTH(DATA_DEPTH)) u_stub (
    .clk(clk), .rst(rst),
    .tf_we(tf_we), .tf_idx(stub_idx), .tf_wdata(bus_wdata[7:0]), .tf_rdata(tf_rdata),
    .ctl_we(ctl_we), .ctl_mask_in(bus_wdata[MASK_BIT]), .mask(mask),
    .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
  );

  ata_win_irq u_irq (
    .clk(clk), .rst(rst), .dev_done(dev_done), .mask(mask),
    .status_rd(status_rd), .irq(irq)
  );

  // R9
  short_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !word_data) |=> bus_ready);

  // R9
  word_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (start && word_data) |=> !bus_ready ##1 bus_ready);

  // R5
  byte_float_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !bus_we && is_byte && sel == SEL_NONE) |=> (bus_rdata == 32'h0000_00FF));

  // R6
  word_float_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !bus_we && is_word && sel == SEL_NONE) |=> (bus_rdata == 32'hFFFF_FFFF));
endmodule

// File: tb/ata_mmio_window_tb.sv
module ata_mmio_window_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req, we, done;
  logic [1:0]  size;
  logic [31:0] addr, wdata;
  logic        rdy_le, rdy_be, irq_le, irq_be;
  logic [31:0] rd_le, rd_be;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  m_tf [8];
  bit          m_mask, m_irq;
  logic [15:0] m_fifo [2][16];
  int          m_wp [2];
  int          m_rp [2];
  int          m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_mmio_window #(.BIG_ENDIAN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_size(size),
    .bus_addr(addr), .bus_wdata(wdata), .bus_ready(rdy_be), .bus_rdata(rd_be),
    .dev_done(done), .irq(irq_be)
  );

  ata_mmio_window #(.BIG_ENDIAN(1'b0)) u_dut_le (
    .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_size(size),
    .bus_addr(addr), .bus_wdata(wdata), .bus_ready(rdy_le), .bus_rdata(rd_le),
    .dev_done(done), .irq(irq_le)
  );

  function automatic logic [15:0] sw16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {sw16(v[15:0]), sw16(v[31:16])};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(input int d, input logic [15:0] v);
    m_fifo[d][m_wp[d]] = v;
    m_wp[d] = (m_wp[d] + 1) % 16;
  endtask
  function automatic logic [15:0] pop(input int d);
    logic [15:0] v;
    v = m_fifo[d][m_rp[d]];
    m_rp[d] = (m_rp[d] + 1) % 16;
    return v;
  endfunction

  // Model of one access; d = 0 little-endian instance, d = 1 big-endian instance.
  task automatic model_op(input bit w, input logic [1:0] sz, input int idx,
                          input logic [31:0] wd, input bit dn,
                          output logic [31:0] e_le, output logic [31:0] e_be,
                          output int e_cyc, output string tag);
    logic [31:0] e [2];
    bit srd = 0;
    e[0] = 0; e[1] = 0; e_cyc = 1;
    if (sz == 2'd0) begin
      if (idx >= 1 && idx <= 7) begin
        tag = "R3";
        if (w) m_tf[idx] = wd[7:0];
        else begin e[0] = {24'd0, m_tf[idx]}; e[1] = e[0]; srd = (idx == 7); end
      end else if (idx == 8 || idx == 22) begin
        tag = "R4";
        if (!w) begin e[0] = {24'd0, m_tf[7]}; e[1] = e[0]; end
      end else begin
        tag = "R5";
        if (!w) begin e[0] = 32'hFF; e[1] = 32'hFF; end
      end
    end else if (idx != 0) begin
      tag = "R6";
      if (!w) begin e[0] = sz[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF; e[1] = e[0]; end
    end else if (!sz[1]) begin
      tag = "R7";
      for (int d = 0; d < 2; d++) begin
        if (w) push(d, d ? sw16(wd[15:0]) : wd[15:0]);
        else begin
          logic [15:0] v;
          v = pop(d);
          e[d] = {16'd0, d ? sw16(v) : v};
        end
      end
      m_cnt += w ? 1 : -1;
    end else begin
      tag = "R8";
      e_cyc = 2;
      for (int d = 0; d < 2; d++) begin
        if (w) begin
          logic [31:0] x;
          x = d ? sw32(wd) : wd;
          push(d, x[15:0]);
          push(d, x[31:16]);
        end else begin
          logic [15:0] lo, hi;
          lo = pop(d);
          hi = pop(d);
          e[d] = d ? sw32({hi, lo}) : {hi, lo};
        end
      end
      m_cnt += w ? 2 : -2;
    end
    if (srd) m_irq = 0;
    if (dn && !m_mask) m_irq = 1;
    if (w && sz == 2'd0 && (idx == 8 || idx == 22)) m_mask = wd[1];
    e_le = e[0];
    e_be = e[1];
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input int idx,
                        input logic [31:0] wd, input bit dn, input logic [31:0] hi_addr);
    logic [31:0] e_le, e_be;
    int e_cyc, cyc;
    string tag;
    model_op(w, sz, idx, wd, dn, e_le, e_be, e_cyc, tag);
    @(negedge clk);
    req = 1; we = w; size = sz; wdata = wd; done = dn;
    addr = {hi_addr[31:12], 8'(idx), hi_addr[3:0]};
    @(negedge clk);
    req = 0; done = 0;
    cyc = 1;
    while (!rdy_be && cyc < 8) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 ready latency", cyc, e_cyc);
    chk("R9 ready match", {31'd0, rdy_le}, 32'd1);
    if (!w) begin
      chk({tag, " le read"}, rd_le, e_le);
      chk({tag, " be read"}, rd_be, e_be);
    end
    chk("R10/R11 irq le", {31'd0, irq_le}, {31'd0, m_irq});
    chk("R10/R11 irq be", {31'd0, irq_be}, {31'd0, m_irq});
  endtask

  task automatic pulse_done(input string tag);
    @(negedge clk);
    done = 1;
    @(negedge clk);
    done = 0;
    if (!m_mask) m_irq = 1;
    chk(tag, {31'd0, irq_be}, {31'd0, m_irq});
    chk(tag, {31'd0, irq_le}, {31'd0, m_irq});
  endtask

  initial begin
    int cyc_count = 0;
    while (!finished && cyc_count < 150000) begin
      @(posedge clk);
      cyc_count++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    req = 0; we = 0; size = 0; addr = 0; wdata = 0; done = 0;
    m_mask = 0; m_irq = 0; m_cnt = 0;
    for (int d = 0; d < 2; d++) begin m_wp[d] = 0; m_rp[d] = 0; end
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 irq after reset", {31'd0, irq_be}, 32'd0);
    chk("R1 ready after reset", {31'd0, rdy_be}, 32'd0);

    // R3: fill and read back task file
    for (int i = 1; i <= 7; i++) access(1, 2'd0, i, 32'h10 * i + 32'h5, 0, 32'h0);
    for (int i = 1; i <= 7; i++) access(0, 2'd0, i, 32'h0, 0, 32'h0);
    // R2: upper and low address bits ignored
    access(1, 2'd0, 3, 32'hFFFF_FF3C, 0, 32'hABCD_E007);
    access(0, 2'd0, 3, 32'h0, 0, 32'h1234_500F);
    // R1, R10: mask clear after reset
    pulse_done("R1 R10 irq set after reset");
    // R4: alternate status leaves irq high
    access(0, 2'd0, 8, 32'h0, 0, 32'h0);
    access(0, 2'd0, 22, 32'h0, 0, 32'h0);
    // R11: status read clears
    access(0, 2'd0, 7, 32'h0, 0, 32'h0);
    // R4, R10: mask via index 22, done ignored
    access(1, 2'd0, 22, 32'h02, 0, 32'h0);
    pulse_done("R10 masked done");
    // R4: unmask via index 8
    access(1, 2'd0, 8, 32'h00, 0, 32'h0);
    pulse_done("R4 R10 unmasked done");
    // R11: done in the same cycle as a status read wins
    access(0, 2'd0, 7, 32'h0, 1, 32'h0);
    access(0, 2'd0, 7, 32'h0, 0, 32'h0);
    // R5: unmapped byte
    access(0, 2'd0, 9, 32'h0, 0, 32'h0);
    access(1, 2'd0, 9, 32'h77, 0, 32'h0);
    access(1, 2'd0, 0, 32'h77, 0, 32'h0);
    for (int i = 1; i <= 7; i++) access(0, 2'd0, i, 32'h0, 0, 32'h0);
    // R6: wide accesses off the data port
    access(0, 2'd1, 3, 32'h0, 0, 32'h0);
    access(0, 2'd2, 5, 32'h0, 0, 32'h0);
    access(0, 2'd3, 1, 32'h0, 0, 32'h0);
    access(1, 2'd1, 4, 32'hBEEF, 0, 32'h0);
    access(1, 2'd2, 4, 32'hDEAD_BEEF, 0, 32'h0);
    access(0, 2'd0, 4, 32'h0, 0, 32'h0);
    // R7, R8: data port ordering and swapping
    access(1, 2'd1, 0, 32'h0000_1234, 0, 32'h0);
    access(0, 2'd1, 0, 32'h0, 0, 32'h0);
    access(1, 2'd2, 0, 32'hAABB_CCDD, 0, 32'h0);
    access(0, 2'd1, 0, 32'h0, 0, 32'h0);
    access(0, 2'd1, 0, 32'h0, 0, 32'h0);
    access(1, 2'd1, 0, 32'h0000_5566, 0, 32'h0);
    access(1, 2'd1, 0, 32'h0000_7788, 0, 32'h0);
    access(0, 2'd2, 0, 32'h0, 0, 32'h0);

    // Random mix
    for (int n = 0; n < 500; n++) begin
      int kind, idx;
      bit w, dn;
      logic [1:0] sz;
      kind = int'($urandom_range(0, 9));
      w = 1'($urandom_range(0, 1));
      dn = ($urandom_range(0, 3) == 0);
      if (kind < 4) begin
        sz = 2'd0;
        case ($urandom_range(0, 3))
          0: idx = 8;
          1: idx = 22;
          2: idx = int'($urandom_range(0, 255));
          default: idx = int'($urandom_range(1, 7));
        endcase
      end else if (kind < 6) begin
        sz = 2'($urandom_range(1, 3));
        idx = int'($urandom_range(1, 255));
      end else begin
        sz = (kind < 8) ? 2'd1 : 2'd2;
        idx = 0;
        if (w && m_cnt + (sz[1] ? 2 : 1) > 16) w = 0;
        if (!w && m_cnt < (sz[1] ? 2 : 1)) w = 1;
      end
      access(w, sz, idx, $urandom, dn, $urandom);
      if ($urandom_range(0, 7) == 0) pulse_done("R10 random done");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule